// File: doc/BRIEF.md
# FIFO-Fed Pulse-Width Modulator

This block produces a single pulse-width modulated waveform whose duty value comes from a small queue of samples. Software fills the queue through a word-wide register port. A period counter is advanced by a programmable clock divider. Each time the counter wraps, the block either reuses the current duty sample or takes the next one from the queue, according to a repeat setting. When the queue runs dry, the last sample stays in force.

Each period starts with the output active. The output stays active until the counter reaches the current sample, then goes inactive until the wrap. A mode field can pass the waveform through unchanged, invert it, or disconnect the pin. Sticky status flags record wraps, compare matches and rejected writes. A self-clearing reset bit returns the whole block to its power-up state.

Register byte offsets are 0x00 for control, 0x04 for status, 0x0C for the sample queue and 0x10 for the period. Reads are combinational from the address. Any other offset reads as zero.

Top module: `pwm_fifo_gen`

## Requirements
- R1: After reset, control, status and period registers read 0x00000000, 0x00000008 and 0x00000000, pwm_out is low and pwm_oe is high.
- R2: With period register value P (P < 0xFFFF), one output period lasts P+2 counter ticks. In normal mode the output is high for the first min(S, P+2) ticks, where S is the current sample.
- R3: Control bits 15:4 hold the divide ratio minus one. Each counter tick lasts that ratio in clock cycles, from 1 up to 4096.
- R4: A period register value of 0xFFFF gives the same period as 0xFFFE, which is 65536 ticks.
- R5: Control bits 19:18 select the output mode. Value 0 is normal. Value 1 is inverted. Values 2 and 3 disconnect the output: pwm_out is low and pwm_oe is low. While control bit 0 (enable) is clear, the waveform is inactive, so pwm_out is low in normal mode and high in inverted mode.
- R6: The write that sets enable loads the oldest queued sample. Control bits 2:1 (values 0..3) make each sample last 1, 2, 4 or 8 periods. The next sample is taken at the wrap that ends the last of these periods. If the queue is empty, the current sample is kept.
- R7: Writing offset 0x0C pushes bits 15:0 into a queue of 4 entries. Status bits 2:0 report the occupancy and status bit 3 is set when the queue is empty.
- R8: A sample write while the queue holds 4 entries is dropped and sets status bit 6.
- R9: Status bit 4 sets at each counter wrap. Status bit 5 sets when the counter equals the current sample while enabled. Bits 4, 5 and 6 stay set until a status write with a 1 in that bit position.
- R10: Writing control with bit 3 set makes bit 3 read as 1 in the following cycle. One cycle later every register, the queue and the outputs are back in their R1 state and bit 3 reads 0.
- R11: Offset 0x0C reads the current sample while enabled and zero while disabled. Control bits 17:16 are stored and read back without changing the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| pwm_out | output | 1 | Modulated output |
| pwm_oe | output | 1 | Output drive enable, low when disconnected |

## Verification
The bench measures the active time within each period window, using windows that start on the enabling write. This catches an off-by-one in the plus-two period length, a divider that counts one cycle short, and the loss of saturation at 0xFFFF (the next period would start one tick late).

Repeat counts of 2 and 8 are checked period by period. A design that pops at every wrap, or fails to hold the last sample when the queue runs dry, shows the wrong sequence of active times.

A fifth write into a full queue must leave the queue contents untouched. The self-clearing reset bit must be visible for exactly one cycle. The inverted and disconnected modes are compared against the idle level as well as the running waveform.

// File: rtl/pwmq_pkg.sv
// Shared definitions for the FIFO-fed PWM block: register offsets,
// status bit positions and the output mode encoding.
package pwmq_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    localparam logic [4:0] OFS_CTRL = 5'h00;
    localparam logic [4:0] OFS_STAT = 5'h04;
    localparam logic [4:0] OFS_SMPL = 5'h0C;
    localparam logic [4:0] OFS_PER  = 5'h10;

    localparam int ST_EMPTY = 3;
    localparam int ST_WRAP  = 4;
    localparam int ST_MATCH = 5;
    localparam int ST_DROP  = 6;

    typedef enum logic [1:0] {
        OUT_PASS = 2'd0,
        OUT_INV  = 2'd1,
        OUT_OFFA = 2'd2,
        OUT_OFFB = 2'd3
    } out_mode_e;
endpackage

// File: rtl/pwmq_prescaler.sv
// Clock divider: emits a one-cycle tick every (div_m1 + 1) clocks while
// enabled. Assumes div_m1 may change at any time; a count at or above
// the new limit ends the current tick interval at once.
module pwmq_prescaler #(
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PRE_W-1:0] div_m1,
    output logic             tick
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [PRE_W-1:0] pcnt;

    // Divider count, held at zero while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)       pcnt <= '0;
        else if (pcnt >= div_m1) pcnt <= '0;
        else                     pcnt <= pcnt + PRE_W'(1);
    end

    assign tick = en && (pcnt >= div_m1);

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_m1 != '0) |=> (!tick || div_m1 == '0)); // R3
endmodule

// File: rtl/pwmq_sample_fifo.sv
// Circular queue of duty samples. Pushes into a full queue are rejected
// even when a pop happens in the same cycle. Pops of an empty queue are
// ignored. Assumes DEPTH >= 2.
module pwmq_sample_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic             wr_ok, rd_ok;

    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
    assign wr_ok = push && !full;
    assign rd_ok = pop && !empty;
    assign head  = mem[rp];

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Storage write, no reset needed for the data itself.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wp] <= push_data;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (wr_ok) wp <= nxt(wp);
            if (rd_ok) rp <= nxt(rp);
            if (wr_ok && !rd_ok)      count <= count + CNT_W'(1);
            else if (rd_ok && !wr_ok) count <= count - CNT_W'(1);
        end
    end

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R7
    AST_FIFO_NO_OVERFILL: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> $stable(count)); // R8
endmodule

// File: rtl/pwmq_wave_core.sv
// Period counter, repeat logic and compare. The counter runs from 0 to
// per_lim + 1 on ticks. The level is active while counter < sample.
// A sample is taken on the enabling write (start) and at a wrap that
// ends the repeat group. Assumes start only arrives while disabled.
module pwmq_wave_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         tick,
    input  logic [W-1:0] per_lim,
    input  logic [1:0]   rep_sel,
    input  logic         start,
    input  logic         fifo_empty,
    input  logic [W-1:0] fifo_head,
    output logic         pop,
    output logic [W-1:0] cur_sample,
    output logic         level,
    output logic         wrap,
    output logic         match
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [W-1:0] cnt;
    logic [W-1:0] top_val;
    logic [2:0]   rep_cnt;
    logic         rep_last;

    assign top_val  = per_lim + W'(1);
    assign wrap     = en && tick && (cnt >= top_val);
    assign rep_last = (rep_cnt == ((3'd1 << rep_sel) - 3'd1));
    assign pop      = !fifo_empty && (start || (wrap && rep_last));
    assign level    = en && (cnt < cur_sample);
    assign match    = en && (cnt == cur_sample);

    // Period counter, cleared while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt <= '0;
        else if (tick)     cnt <= (cnt >= top_val) ? '0 : cnt + W'(1);
    end

    // Count of periods spent on the current sample.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) rep_cnt <= '0;
        else if (wrap)     rep_cnt <= rep_last ? 3'd0 : rep_cnt + 3'd1;
    end

    // Current duty sample, replaced on each pop.
    always_ff @(posedge clk) begin
        if (!rst_n)   cur_sample <= '0;
        else if (pop) cur_sample <= fifo_head;
    end

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0)); // R2
    AST_REPEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !rep_last) |=> $stable(cur_sample)); // R6
endmodule

// File: rtl/pwm_fifo_gen.sv
// Top of the FIFO-fed PWM: register bank, status flags, self-clearing
// reset and output mode stage around the divider, queue and wave core.
// Assumes one register write per cycle; reads are combinational.
module pwm_fifo_gen #(
    parameter int W     = 16,
    parameter int PRE_W = 12,
    parameter int DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [4:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        pwm_out,
    output logic        pwm_oe
);
    timeunit 1ns;
    timeprecision 100ps;
    import pwmq_pkg::*;

    localparam int CNT_W   = $clog2(DEPTH + 1);
    localparam int PRE_LO  = 4;
    localparam int CSEL_LO = PRE_LO + PRE_W;
    localparam int MODE_LO = CSEL_LO + 2;
    localparam logic [W-1:0] PER_SAT = {{(W-1){1'b1}}, 1'b0};

    logic             en_q, swr_q;
    logic [1:0]       rep_q, csel_q;
    logic [PRE_W-1:0] pre_q;
    out_mode_e        mode_q;
    logic [W-1:0]     per_q, per_eff;
    logic             wrap_f, match_f, drop_f;
    logic             int_rst_n;
    logic             wr_ctrl, wr_stat, push, start;
    logic             tick, pop, level, wrap, match;
    logic [W-1:0]     head, cur_sample;
    logic [CNT_W-1:0] fcount;
    logic             fempty, ffull;
    logic             wdata_unused;

    assign wdata_unused = ^reg_wdata[31:MODE_LO+2];
    assign int_rst_n = rst_n && !swr_q;
    assign wr_ctrl   = reg_we && (reg_addr == OFS_CTRL);
    assign wr_stat   = reg_we && (reg_addr == OFS_STAT);
    assign push      = reg_we && (reg_addr == OFS_SMPL);
    assign start     = wr_ctrl && reg_wdata[0] && !reg_wdata[3] && !en_q;
    assign per_eff   = (per_q == '1) ? PER_SAT : per_q;

    // Control register; a reset request writes only the self-clearing bit.
    always_ff @(posedge clk) begin
        if (!int_rst_n) begin
            en_q   <= 1'b0;
            swr_q  <= 1'b0;
            rep_q  <= '0;
            pre_q  <= '0;
            csel_q <= '0;
            mode_q <= OUT_PASS;
        end else if (wr_ctrl) begin
            if (reg_wdata[3]) begin
                swr_q <= 1'b1;
            end else begin
                en_q   <= reg_wdata[0];
                rep_q  <= reg_wdata[2:1];
                pre_q  <= reg_wdata[PRE_LO +: PRE_W];
                csel_q <= reg_wdata[CSEL_LO +: 2];
                mode_q <= out_mode_e'(reg_wdata[MODE_LO +: 2]);
            end
        end
    end

    // Period register.
    always_ff @(posedge clk) begin
        if (!int_rst_n)                       per_q <= '0;
        else if (reg_we && reg_addr == OFS_PER) per_q <= reg_wdata[W-1:0];
    end

    // Sticky status flags: an event sets, a write of 1 clears.
    always_ff @(posedge clk) begin
        if (!int_rst_n) begin
            wrap_f  <= 1'b0;
            match_f <= 1'b0;
            drop_f  <= 1'b0;
        end else begin
            wrap_f  <= wrap  || (wrap_f  && !(wr_stat && reg_wdata[ST_WRAP]));
            match_f <= match || (match_f && !(wr_stat && reg_wdata[ST_MATCH]));
            drop_f  <= (push && ffull) || (drop_f && !(wr_stat && reg_wdata[ST_DROP]));
        end
    end

    pwmq_prescaler #(.PRE_W(PRE_W)) u_div (
        .clk    (clk),
        .rst_n  (int_rst_n),
        .en     (en_q),
        .div_m1 (pre_q),
        .tick   (tick)
    );

    pwmq_sample_fifo #(.DEPTH(DEPTH), .W(W)) u_fifo (
        .clk       (clk),
        .rst_n     (int_rst_n),
        .push      (push),
        .push_data (reg_wdata[W-1:0]),
        .pop       (pop),
        .head      (head),
        .count     (fcount),
        .empty     (fempty),
        .full      (ffull)
    );

    pwmq_wave_core #(.W(W)) u_core (
        .clk        (clk),
        .rst_n      (int_rst_n),
        .en         (en_q),
        .tick       (tick),
        .per_lim    (per_eff),
        .rep_sel    (rep_q),
        .start      (start),
        .fifo_empty (fempty),
        .fifo_head  (head),
        .pop        (pop),
        .cur_sample (cur_sample),
        .level      (level),
        .wrap       (wrap),
        .match      (match)
    );

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL: begin
                reg_rdata[0]                = en_q;
                reg_rdata[2:1]              = rep_q;
                reg_rdata[3]                = swr_q;
                reg_rdata[PRE_LO +: PRE_W]  = pre_q;
                reg_rdata[CSEL_LO +: 2]     = csel_q;
                reg_rdata[MODE_LO +: 2]     = mode_q;
            end
            OFS_STAT: begin
                reg_rdata[CNT_W-1:0] = fcount;
                reg_rdata[ST_EMPTY]  = fempty;
                reg_rdata[ST_WRAP]   = wrap_f;
                reg_rdata[ST_MATCH]  = match_f;
                reg_rdata[ST_DROP]   = drop_f;
            end
            OFS_SMPL: reg_rdata[W-1:0] = en_q ? cur_sample : '0;
            OFS_PER:  reg_rdata[W-1:0] = per_q;
            default:  reg_rdata = '0;
        endcase
    end

    // Output mode stage.
    always_comb begin
        case (mode_q)
            OUT_PASS: begin pwm_out = level;  pwm_oe = 1'b1; end
            OUT_INV:  begin pwm_out = !level; pwm_oe = 1'b1; end
            default:  begin pwm_out = 1'b0;   pwm_oe = 1'b0; end
        endcase
    end

    AST_SWR_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        swr_q |=> !swr_q); // R10
    AST_DROP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (push && ffull && !swr_q) |=> drop_f); // R8
    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !swr_q) |=> wrap_f); // R9
endmodule

// File: tb/pwm_fifo_gen_tb_top.sv
// Self-checking bench: directed corner cases plus seeded random periods.
module pwm_fifo_gen_tb_top;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pwm_out, pwm_oe;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = !clk;

    pwm_fifo_gen dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pwm_out(pwm_out), .pwm_oe(pwm_oe)
    );

    function automatic logic [31:0] cw(int en, int rep, int pre, int csel, int mode);
        return 32'((mode << 18) | (csel << 16) | (pre << 4) | (rep << 1) | en);
    endfunction

    function automatic int exp_high(int s, int per, int pre);
        int lim = (per >= 65535) ? 65534 : per;
        return ((s < lim + 2) ? s : lim + 2) * (pre + 1);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic window(int p, output int h);
        h = 0;
        for (int i = 0; i < p; i++) begin
            if (pwm_out) h++;
            @(negedge clk);
        end
    endtask

    task automatic swreset();
        wr(5'h00, 32'h8);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int h, seed_v;
        seed_v = $urandom(32'd2024);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(5'h00, d); check("R1 ctrl", d, 32'h0);
        rd(5'h04, d); check("R1 status", d, 32'h8);
        rd(5'h10, d); check("R1 period", d, 32'h0);
        check("R1 out", 32'(pwm_out), 32'd0);
        check("R1 oe", 32'(pwm_oe), 32'd1);

        // R2 basic period, R9 flags, R11 sample read
        wr(5'h10, 32'd5);
        wr(5'h0C, 32'd3);
        wr(5'h00, cw(1, 0, 0, 0, 0));
        window(7, h); check("R2 high ticks p1", 32'(h), 32'(exp_high(3, 5, 0)));
        window(7, h); check("R2 high ticks p2", 32'(h), 32'(exp_high(3, 5, 0)));
        rd(5'h0C, d); check("R11 sample enabled", d, 32'd3);
        rd(5'h04, d); check("R9 wrap+match set", (d >> 4) & 32'h3, 32'h3);
        wr(5'h00, cw(0, 0, 0, 0, 0));
        rd(5'h0C, d); check("R11 sample disabled", d, 32'd0);
        wr(5'h04, 32'h70);
        rd(5'h04, d); check("R9 w1c", (d >> 4) & 32'h7, 32'h0);

        // R10 self-clearing reset
        wr(5'h00, 32'h8);
        rd(5'h00, d); check("R10 bit visible", d & 32'h8, 32'h8);
        @(negedge clk);
        rd(5'h00, d); check("R10 ctrl cleared", d, 32'h0);
        rd(5'h10, d); check("R10 period cleared", d, 32'h0);
        rd(5'h04, d); check("R10 status cleared", d, 32'h8);

        // R3 prescaler divide by 3
        wr(5'h10, 32'd4);
        wr(5'h0C, 32'd2);
        wr(5'h00, cw(1, 0, 2, 0, 0));
        window(18, h); check("R3 divided high", 32'(h), 32'(exp_high(2, 4, 2)));

        // R5 inverted, idle level, disconnected; R11 clock select readback
        swreset();
        wr(5'h10, 32'd5);
        wr(5'h0C, 32'd2);
        wr(5'h00, cw(1, 0, 0, 0, 1));
        window(7, h); check("R5 inverted high", 32'(h), 32'(7 - exp_high(2, 5, 0)));
        wr(5'h00, cw(0, 0, 0, 0, 1));
        check("R5 inverted idle", 32'(pwm_out), 32'd1);
        wr(5'h00, cw(1, 0, 0, 0, 2));
        window(7, h); check("R5 off high", 32'(h), 32'd0);
        check("R5 off oe", 32'(pwm_oe), 32'd0);
        wr(5'h00, cw(0, 0, 0, 3, 0));
        rd(5'h00, d); check("R11 clock select", d, cw(0, 0, 0, 3, 0));

        // R6 repeat x2 then hold
        swreset();
        wr(5'h10, 32'd3);
        wr(5'h0C, 32'd1); wr(5'h0C, 32'd2); wr(5'h0C, 32'd3);
        wr(5'h00, cw(1, 1, 0, 0, 0));
        begin
            int exp_seq[8] = '{1, 1, 2, 2, 3, 3, 3, 3};
            for (int k = 0; k < 8; k++) begin
                window(5, h); check("R6 repeat x2", 32'(h), 32'(exp_seq[k]));
            end
        end

        // R6 repeat x8
        swreset();
        wr(5'h10, 32'd1);
        wr(5'h0C, 32'd1); wr(5'h0C, 32'd2);
        wr(5'h00, cw(1, 3, 0, 0, 0));
        for (int k = 0; k < 10; k++) begin
            window(3, h); check("R6 repeat x8", 32'(h), (k < 8) ? 32'd1 : 32'd2);
        end

        // R7/R8 full queue, dropped write, held last sample
        swreset();
        wr(5'h10, 32'd5);
        wr(5'h0C, 32'd1); wr(5'h0C, 32'd2); wr(5'h0C, 32'd3); wr(5'h0C, 32'd4);
        rd(5'h04, d); check("R7 count full", d, 32'h4);
        wr(5'h0C, 32'd9);
        rd(5'h04, d); check("R8 drop flag", d, 32'h44);
        wr(5'h00, cw(1, 0, 0, 0, 0));
        begin
            int exp_seq[5] = '{1, 2, 3, 4, 4};
            for (int k = 0; k < 5; k++) begin
                window(7, h); check("R8 dropped not queued", 32'(h), 32'(exp_seq[k]));
            end
        end
        rd(5'h04, d); check("R7 empty", d & 32'hF, 32'h8);

        // R2/R3 seeded random periods
        for (int t = 0; t < 6; t++) begin
            int per = 1 + int'($urandom % 20);
            int pre = int'($urandom % 4);
            int s   = int'($urandom % 25);
            swreset();
            wr(5'h10, 32'(per));
            wr(5'h0C, 32'(s));
            wr(5'h00, cw(1, 0, pre, 0, 0));
            window((per + 2) * (pre + 1), h);
            check("R2 R3 random", 32'(h), 32'(exp_high(s, per, pre)));
        end

        // R4 saturation of the period register
        swreset();
        wr(5'h10, 32'hFFFF);
        wr(5'h0C, 32'd1);
        wr(5'h00, cw(1, 0, 0, 0, 0));
        window(65536, h); check("R4 saturated high", 32'(h), 32'd1);
        check("R4 next period start", 32'(pwm_out), 32'd1);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule